// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the general-purpose registers of a 32-bit processor core with sixteen architectural indices, index 15 being the program counter. The processor mode sits in the low five bits of the current status word, and it decides which physical copy answers each architectural index. User and System share one set. The fast-interrupt mode has private copies of indices 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of the stack pointer (13) and link register (14) only. Every exception mode also owns a saved status word.

The core reads two operands and writes one result per cycle, all addressed by architectural index. It changes mode by writing the control field of the current status word. Both status words are written through a two-bit field select, so only the flag nibble and the control byte can change. Mode codes outside the seven legal ones raise a flag. While that flag is set the block uses the User register mapping, and no saved status word is reachable.

Top module: `bank_regfile`

## Requirements
- R1: A synchronous reset sets the current status word to 32'h0000_0013 (Supervisor mode, all other bits zero) and clears every physical register copy and every saved status word to zero.
- R2: Mode codes 5'b10000 (User) and 5'b11111 (System) read and write the same physical registers for indices 0 to 14.
- R3: In mode 5'b10001 (fast interrupt), indices 8 to 14 reach seven private copies, and indices 0 to 7 reach the shared copies.
- R4: In modes 5'b10010, 5'b10011, 5'b10111 and 5'b11011, only indices 13 and 14 reach private per-mode copies, and indices 0 to 12 reach the shared copies.
- R5: Index 15 is a single program counter, written and read identically in every mode.
- R6: A current-status write with select bit 1 set replaces bits [31:28], and with select bit 0 set replaces bits [7:0]. Bits [27:8] and any unselected field keep their previous value.
- R7: Each of the five exception modes has its own saved status word, read and written only while that mode is current, using the same field select as R6.
- R8: In User or System mode the saved-status read port returns zero and a saved-status write is discarded.
- R9: A mode code other than the seven legal ones sets mode_illegal to 1. Registers then map as in User mode, and saved-status access behaves as in R8.
- R10: Register and saved-status accesses use the mode held before the clock edge, even when the same cycle also writes a new mode.
- R11: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle on.
- R12: The two read ports are independent; each returns the register named by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | DATA_W | Read data, port A (combinational) |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | DATA_W | Read data, port B (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | DATA_W | Register write data |
| cpsr_wr_en | input | 1 | Current-status write enable |
| cpsr_wr_mask | input | 2 | Field select: bit 1 flags [31:28], bit 0 control [7:0] |
| cpsr_wdata | input | 32 | Current-status write data |
| cpsr_rdata | output | 32 | Current-status word |
| spsr_wr_en | input | 1 | Saved-status write enable |
| spsr_wr_mask | input | 2 | Field select, same encoding as cpsr_wr_mask |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rdata | output | 32 | Saved status of the current mode, zero if the mode has none |
| mode_illegal | output | 1 | Current mode code is not one of the seven legal codes |

## Verification
A wrong bank mapping does not show when the write lands. It shows only when the same index is read back in a different mode, so the bench writes distinct values in several modes and reads every private and shared copy back across mode changes. A fault in the status-field merge shows on the status read port one cycle after the write. A fault in the timing of the mode switch shows as a value landing in the wrong bank, and it becomes visible only after a later switch back to the mode that should have received it.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

    localparam int PSR_W       = 32;
    localparam int ARCH_IDX_W  = 4;
    localparam int MODE_W      = 5;
    localparam int SHARED_N    = 15;
    localparam int FIQ_N       = 7;
    localparam int EXC_PAIR_N  = 2;
    localparam int EXC_SMALL_N = 4;
    localparam int FIQ_BASE    = SHARED_N;
    localparam int EXC_BASE    = FIQ_BASE + FIQ_N;
    localparam int PC_PHYS     = EXC_BASE + EXC_PAIR_N * EXC_SMALL_N;
    localparam int PHYS_N      = PC_PHYS + 1;
    localparam int PHYS_IDX_W  = $clog2(PHYS_N);
    localparam int N_SPSR      = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam logic [PSR_W-1:0] PSR_FLAG_MASK = 32'hF000_0000;
    localparam logic [PSR_W-1:0] PSR_CTRL_MASK = 32'h0000_00FF;
    localparam logic [PSR_W-1:0] PSR_RESET     = {27'd0, MODE_SVC};

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        bank_e bank;
        logic  legal;
        logic  has_spsr;
    } mode_info_t;

    function automatic mode_info_t decode_mode(logic [MODE_W-1:0] m);
        mode_info_t r;
        r = '{bank: BK_USR, legal: 1'b1, has_spsr: 1'b0};
        case (m)
            MODE_USR, MODE_SYS: r = '{bank: BK_USR, legal: 1'b1, has_spsr: 1'b0};
            MODE_FIQ: r = '{bank: BK_FIQ, legal: 1'b1, has_spsr: 1'b1};
            MODE_IRQ: r = '{bank: BK_IRQ, legal: 1'b1, has_spsr: 1'b1};
            MODE_SVC: r = '{bank: BK_SVC, legal: 1'b1, has_spsr: 1'b1};
            MODE_ABT: r = '{bank: BK_ABT, legal: 1'b1, has_spsr: 1'b1};
            MODE_UND: r = '{bank: BK_UND, legal: 1'b1, has_spsr: 1'b1};
            default:  r = '{bank: BK_USR, legal: 1'b0, has_spsr: 1'b0};
        endcase
        return r;
    endfunction

    // Physical layout: 0..14 shared, 15..21 fast-interrupt 8..14,
    // 22..29 stack/link pairs for the four small banks, 30 program counter.
    function automatic logic [PHYS_IDX_W-1:0] map_phys(logic [ARCH_IDX_W-1:0] a, bank_e b);
        logic [PHYS_IDX_W-1:0] r;
        logic [2:0]            k;
        r = {1'b0, a};
        k = 3'(b) - 3'(BK_IRQ);
        if (a == 4'd15) begin
            r = PHYS_IDX_W'(PC_PHYS);
        end else if (b == BK_FIQ && a >= 4'd8) begin
            r = PHYS_IDX_W'(FIQ_BASE) + {2'b00, a[2:0]};
        end else if ((b == BK_IRQ || b == BK_SVC || b == BK_ABT || b == BK_UND) && a >= 4'd13) begin
            r = PHYS_IDX_W'(EXC_BASE) + {1'b0, k, 1'b0} + ((a == 4'd14) ? 5'd1 : 5'd0);
        end
        return r;
    endfunction

    function automatic logic [PSR_W-1:0] psr_merge(logic [PSR_W-1:0] old_v,
                                                   logic [PSR_W-1:0] new_v,
                                                   logic [1:0]       sel);
        logic [PSR_W-1:0] m;
        m = '0;
        if (sel[1]) m = m | PSR_FLAG_MASK;
        if (sel[0]) m = m | PSR_CTRL_MASK;
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/brf_status.sv
module brf_status
    import bank_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cpsr_wr_en,
    input  logic [1:0]       cpsr_wr_mask,
    input  logic [PSR_W-1:0] cpsr_wdata,
    output logic [PSR_W-1:0] cpsr_rdata,
    input  logic             spsr_wr_en,
    input  logic [1:0]       spsr_wr_mask,
    input  logic [PSR_W-1:0] spsr_wdata,
    output logic [PSR_W-1:0] spsr_rdata,
    output mode_info_t       minfo
);
    logic [PSR_W-1:0] cpsr_q;
    logic [PSR_W-1:0] spsr_q [N_SPSR];
    logic [2:0]       spsr_sel;

    assign minfo      = decode_mode(cpsr_q[MODE_W-1:0]);
    assign cpsr_rdata = cpsr_q;
    assign spsr_sel   = 3'(minfo.bank) - 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpsr_q <= PSR_RESET;
        end else if (cpsr_wr_en) begin
            cpsr_q <= psr_merge(cpsr_q, cpsr_wdata, cpsr_wr_mask);
        end
    end

    for (genvar g = 0; g < N_SPSR; g++) begin : g_spsr
        always_ff @(posedge clk) begin
            if (rst) begin
                spsr_q[g] <= '0;
            end else if (spsr_wr_en && minfo.has_spsr && spsr_sel == 3'(g)) begin
                spsr_q[g] <= psr_merge(spsr_q[g], spsr_wdata, spsr_wr_mask);
            end
        end
    end

    always_comb begin
        spsr_rdata = '0;
        for (int i = 0; i < N_SPSR; i++) begin
            if (minfo.has_spsr && spsr_sel == 3'(i)) spsr_rdata = spsr_q[i];
        end
    end

endmodule

// File: rtl/brf_port_map.sv
module brf_port_map
    import bank_rf_pkg::*;
#(
    parameter int N_PORTS = 3
) (
    input  logic  [N_PORTS-1:0][ARCH_IDX_W-1:0] arch_idx,
    input  bank_e                               bank,
    output logic  [N_PORTS-1:0][PHYS_IDX_W-1:0] phys_idx
);
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign phys_idx[p] = map_phys(arch_idx[p], bank);
    end
endmodule

// File: rtl/brf_gpr_bank.sv
module brf_gpr_bank
    import bank_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [PHYS_IDX_W-1:0] waddr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [PHYS_IDX_W-1:0] raddr_a,
    input  logic [PHYS_IDX_W-1:0] raddr_b,
    output logic [DATA_W-1:0]     rdata_a,
    output logic [DATA_W-1:0]     rdata_b
);
    logic [DATA_W-1:0] cell_q [PHYS_N];

    for (genvar g = 0; g < PHYS_N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q[g] <= '0;
            end else if (we && waddr == PHYS_IDX_W'(g)) begin
                cell_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < PHYS_N; i++) begin
            if (raddr_a == PHYS_IDX_W'(i)) rdata_a = cell_q[i];
            if (raddr_b == PHYS_IDX_W'(i)) rdata_b = cell_q[i];
        end
    end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpsr_wr_en,
    input  logic [1:0]        cpsr_wr_mask,
    input  logic [31:0]       cpsr_wdata,
    output logic [31:0]       cpsr_rdata,
    input  logic              spsr_wr_en,
    input  logic [1:0]        spsr_wr_mask,
    input  logic [31:0]       spsr_wdata,
    output logic [31:0]       spsr_rdata,
    output logic              mode_illegal
);
    localparam int N_PORTS = 3;

    mode_info_t                             minfo;
    logic [N_PORTS-1:0][ARCH_IDX_W-1:0]     arch_idx;
    logic [N_PORTS-1:0][PHYS_IDX_W-1:0]     phys_idx;

    assign arch_idx[0] = wr_idx;
    assign arch_idx[1] = rd_a_idx;
    assign arch_idx[2] = rd_b_idx;

    brf_status u_status (
        .clk          (clk),
        .rst          (rst),
        .cpsr_wr_en   (cpsr_wr_en),
        .cpsr_wr_mask (cpsr_wr_mask),
        .cpsr_wdata   (cpsr_wdata),
        .cpsr_rdata   (cpsr_rdata),
        .spsr_wr_en   (spsr_wr_en),
        .spsr_wr_mask (spsr_wr_mask),
        .spsr_wdata   (spsr_wdata),
        .spsr_rdata   (spsr_rdata),
        .minfo        (minfo)
    );

    brf_port_map #(.N_PORTS(N_PORTS)) u_map (
        .arch_idx (arch_idx),
        .bank     (minfo.bank),
        .phys_idx (phys_idx)
    );

    brf_gpr_bank #(.DATA_W(DATA_W)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (phys_idx[0]),
        .wdata   (wr_data),
        .raddr_a (phys_idx[1]),
        .raddr_b (phys_idx[2]),
        .rdata_a (rd_a_data),
        .rdata_b (rd_b_data)
    );

    assign mode_illegal = ~minfo.legal;

endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              cpsr_wr_en,
    input logic [1:0]        cpsr_wr_mask,
    input logic [31:0]       cpsr_rdata,
    input logic [31:0]       spsr_rdata,
    input logic              mode_illegal
);
    p_write_then_read_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cpsr_wr_en) |=> (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

    p_pc_shared_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 4'd15) |=> (rd_a_idx != 4'd15 || rd_a_data == $past(wr_data)));

    p_reserved_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cpsr_wr_en |=> cpsr_rdata[27:8] == $past(cpsr_rdata[27:8]));

    p_flags_unselected_r6: assert property (@(posedge clk) disable iff (rst)
        (cpsr_wr_en && !cpsr_wr_mask[1]) |=> $stable(cpsr_rdata[31:28]));

    p_ctrl_unselected_r6: assert property (@(posedge clk) disable iff (rst)
        (cpsr_wr_en && !cpsr_wr_mask[0]) |=> $stable(cpsr_rdata[7:0]));

    p_no_saved_user_r8: assert property (@(posedge clk) disable iff (rst)
        (cpsr_rdata[4:0] == 5'b10000 || cpsr_rdata[4:0] == 5'b11111) |-> spsr_rdata == 32'd0);

    p_illegal_no_saved_r9: assert property (@(posedge clk) disable iff (rst)
        mode_illegal |-> spsr_rdata == 32'd0);
endmodule

bind bank_regfile brf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .cpsr_wr_en   (cpsr_wr_en),
    .cpsr_wr_mask (cpsr_wr_mask),
    .cpsr_rdata   (cpsr_rdata),
    .spsr_rdata   (spsr_rdata),
    .mode_illegal (mode_illegal)
);

// File: tb/tb_bank_regfile.sv
module tb_bank_regfile;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, cpsr_wr_en = 1'b0, spsr_wr_en = 1'b0;
    logic [1:0]    cpsr_wr_mask = '0, spsr_wr_mask = '0;
    logic [31:0]   cpsr_wdata = '0, cpsr_rdata, spsr_wdata = '0, spsr_rdata;
    logic          mode_illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bank_regfile #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_mask(cpsr_wr_mask),
        .cpsr_wdata(cpsr_wdata), .cpsr_rdata(cpsr_rdata),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_mask(spsr_wr_mask),
        .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
        .mode_illegal(mode_illegal)
    );

    // Entry: {is_write, mode, index, data}. For reads, data is the expected value.
    localparam int NV = 24;
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 5'h13, 4'd0,  32'h0000_0100},
        {1'b1, 5'h13, 4'd13, 32'h0000_113D},
        {1'b1, 5'h10, 4'd13, 32'h0000_1013},
        {1'b1, 5'h11, 4'd8,  32'h0000_0F08},
        {1'b1, 5'h11, 4'd14, 32'h0000_0F0E},
        {1'b1, 5'h12, 4'd14, 32'h0000_120E},
        {1'b1, 5'h17, 4'd13, 32'h0000_170D},
        {1'b1, 5'h1B, 4'd13, 32'h0000_1B0D},
        {1'b1, 5'h1F, 4'd8,  32'h0000_1F08},
        {1'b1, 5'h11, 4'd15, 32'h0000_AAAA},
        {1'b0, 5'h10, 4'd0,  32'h0000_0100},
        {1'b0, 5'h10, 4'd13, 32'h0000_1013},
        {1'b0, 5'h1F, 4'd13, 32'h0000_1013},
        {1'b0, 5'h13, 4'd13, 32'h0000_113D},
        {1'b0, 5'h11, 4'd13, 32'h0000_0000},
        {1'b0, 5'h11, 4'd8,  32'h0000_0F08},
        {1'b0, 5'h10, 4'd8,  32'h0000_1F08},
        {1'b0, 5'h12, 4'd14, 32'h0000_120E},
        {1'b0, 5'h12, 4'd13, 32'h0000_0000},
        {1'b0, 5'h17, 4'd13, 32'h0000_170D},
        {1'b0, 5'h1B, 4'd13, 32'h0000_1B0D},
        {1'b0, 5'h10, 4'd15, 32'h0000_AAAA},
        {1'b0, 5'h13, 4'd14, 32'h0000_0000},
        {1'b0, 5'h11, 4'd0,  32'h0000_0100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [4:0] m);
        @(negedge clk);
        cpsr_wr_en = 1'b1; cpsr_wr_mask = 2'b01; cpsr_wdata = {24'd0, 3'b000, m};
        @(negedge clk);
        cpsr_wr_en = 1'b0;
    endtask

    task automatic write_reg(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_a(input string req, input logic [3:0] i, input logic [31:0] exp);
        rd_a_idx = i;
        #1;
        chk(req, rd_a_data, exp);
    endtask

    task automatic write_spsr(input logic [1:0] msk, input logic [31:0] d);
        @(negedge clk);
        spsr_wr_en = 1'b1; spsr_wr_mask = msk; spsr_wdata = d;
        @(negedge clk);
        spsr_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        chk("R1 cpsr", cpsr_rdata, 32'h0000_0013);
        chk("R1 illegal", {31'd0, mode_illegal}, 32'd0);
        chk("R1 spsr", spsr_rdata, 32'd0);
        read_a("R1 r0", 4'd0, 32'd0);
        read_a("R1 r13", 4'd13, 32'd0);

        // Table walk: R2 shared, R3 fast-interrupt bank, R4 small banks, R5 PC, R12 port B
        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            string       tag;
            v = VEC[i];
            set_mode(v[40:36]);
            if (v[41]) begin
                write_reg(v[35:32], v[31:0]);
            end else begin
                if (v[35:32] == 4'd15)      tag = "R5";
                else if (v[40:36] == 5'h11) tag = "R3";
                else if (v[40:36] == 5'h10 || v[40:36] == 5'h1F) tag = "R2";
                else                         tag = "R4";
                rd_b_idx = v[35:32];
                read_a(tag, v[35:32], v[31:0]);
                chk({tag, " portB R12"}, rd_b_data, v[31:0]);
            end
        end

        // R11: read during write returns old, new after edge
        set_mode(5'h10);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h999; rd_a_idx = 4'd0;
        #1 chk("R11 old", rd_a_data, 32'h100);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R11 new", rd_a_data, 32'h999);

        // R10: mode write and register write in the same cycle
        @(negedge clk);
        cpsr_wr_en = 1'b1; cpsr_wr_mask = 2'b01; cpsr_wdata = 32'h13;
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h777;
        @(negedge clk);
        cpsr_wr_en = 1'b0; wr_en = 1'b0;
        read_a("R10 svc r13 untouched", 4'd13, 32'h113D);
        set_mode(5'h10);
        read_a("R10 user r13 written", 4'd13, 32'h777);

        // R6: field-select writes of the current status word
        @(negedge clk);
        cpsr_wr_en = 1'b1; cpsr_wr_mask = 2'b10; cpsr_wdata = 32'h5FFF_FF00;
        @(negedge clk);
        cpsr_wr_en = 1'b0;
        #1 chk("R6 flags only", cpsr_rdata, 32'h5000_0010);
        @(negedge clk);
        cpsr_wr_en = 1'b1; cpsr_wr_mask = 2'b00; cpsr_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cpsr_wr_en = 1'b0;
        #1 chk("R6 no field", cpsr_rdata, 32'h5000_0010);
        @(negedge clk);
        cpsr_wr_en = 1'b1; cpsr_wr_mask = 2'b11; cpsr_wdata = 32'hA123_45D0;
        @(negedge clk);
        cpsr_wr_en = 1'b0;
        #1 chk("R6 both fields", cpsr_rdata, 32'hA000_00D0);

        // R8: no saved status in User/System
        set_mode(5'h10);
        write_spsr(2'b11, 32'h1234_5678);
        #1 chk("R8 user read", spsr_rdata, 32'd0);
        set_mode(5'h1F);
        #1 chk("R8 system read", spsr_rdata, 32'd0);
        set_mode(5'h13);
        #1 chk("R8 write discarded", spsr_rdata, 32'd0);

        // R7: per-mode saved status with field select
        write_spsr(2'b11, 32'hFFFF_FFFF);
        #1 chk("R7 svc fields", spsr_rdata, 32'hF000_00FF);
        set_mode(5'h12);
        #1 chk("R7 irq separate", spsr_rdata, 32'd0);
        write_spsr(2'b10, 32'hA000_00FF);
        #1 chk("R7 irq flags only", spsr_rdata, 32'hA000_0000);
        set_mode(5'h13);
        #1 chk("R7 svc kept", spsr_rdata, 32'hF000_00FF);

        // R9: illegal mode code
        set_mode(5'b10100);
        #1 chk("R9 flag", {31'd0, mode_illegal}, 32'd1);
        chk("R9 spsr", spsr_rdata, 32'd0);
        read_a("R9 user map r13", 4'd13, 32'h777);
        write_reg(4'd14, 32'hE14);
        set_mode(5'h10);
        #1 chk("R9 flag clear", {31'd0, mode_illegal}, 32'd0);
        read_a("R9 user r14", 4'd14, 32'hE14);
        set_mode(5'h13);
        read_a("R9 svc r14 untouched", 4'd14, 32'd0);

        // R12: two ports on different registers
        set_mode(5'h10);
        rd_b_idx = 4'd13;
        read_a("R12 port A", 4'd0, 32'h999);
        chk("R12 port B", rd_b_data, 32'h777);

        // R1: reset again clears banked copies
        do_reset();
        #1 chk("R1 cpsr again", cpsr_rdata, 32'h0000_0013);
        read_a("R1 svc r13 cleared", 4'd13, 32'd0);
        chk("R1 svc spsr cleared", spsr_rdata, 32'd0);
        read_a("R1 pc cleared", 4'd15, 32'd0);
        set_mode(5'h11);
        read_a("R1 fiq r8 cleared", 4'd8, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule